// File: doc/BRIEF.md
# Rotated Immediate Codec

This block converts between 32-bit constants and a compact 12-bit immediate field. The field holds an 8-bit base and a 4-bit rotate count. Its value is the base, zero-extended to 32 bits, rotated right by twice the count. Because only even rotations from 0 to 30 are allowed, a 12-bit field can reach constants all over the 32-bit range, not only the values below 4096. For example, a base of 65 with a count of 15 rotates right by 30, which is the same as a left rotation by 2, so the field gives 260.

The decode path is purely combinational: a field goes in and the 32-bit value comes out in the same cycle. The encode path is a small sequential search. A producer hands it a 32-bit constant through a valid/ready handshake. The search then tries rotate counts from 0 upward, one per clock cycle, and stops at the first count that brings the whole constant into the low 8 bits. Many constants have more than one encoding, so taking the smallest count makes the result deterministic. When no count works, the encoder raises a flag saying the constant cannot be encoded. The result is held until the consumer acknowledges it.

Top module: `rotimm_codec`

## Requirements
- R1: The decoder output equals the low 8 field bits, zero-extended to 32 bits and rotated right by twice the value in field bits 11:8. It reacts in the same cycle, with no clock involved.
- R2: Field 0xF41 (count 15, base 65) decodes to 260, and field 0x4FF decodes to 0xFF000000.
- R3: `enc_ready_o` is high only while the encoder is idle. `enc_valid_i` is ignored while it is low, including in the cycle that acknowledges a result.
- R4: When several encodings exist, the encoder reports the smallest count. The value 1 encodes as 0x001, 260 as 0xF41, 1020 as 0xFFF and 0xF000000F as 0x2FF.
- R5: If a constant is accepted at a clock edge and its smallest count is c, `enc_done_o` rises c+1 edges later with `enc_unenc_o` low.
- R6: If no count fits, `enc_done_o` and `enc_unenc_o` rise together 16 edges after acceptance, and `enc_field_o` is zero.
- R7: While `enc_done_o` is high and `enc_ack_i` is low, the done flag, the unencodable flag and the field stay unchanged. An acknowledged result makes the encoder ready at the next edge.
- R8: A synchronous active-high `rst` makes the encoder ready, with done and the unencodable flag low, even in the middle of a search.
- R9: Whenever the encoder reports success, passing `enc_field_o` through the decoder gives back exactly the accepted constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_field_i | input | 12 | Field to expand |
| dec_value_o | output | 32 | Expanded constant |
| enc_valid_i | input | 1 | Constant offered to the encoder |
| enc_ready_o | output | 1 | Encoder idle and accepting |
| enc_value_i | input | 32 | Constant to encode |
| enc_done_o | output | 1 | Encoder result available |
| enc_unenc_o | output | 1 | Constant has no encoding (qualified by done) |
| enc_field_o | output | 12 | Encoded field (qualified by done) |
| enc_ack_i | input | 1 | Consumer takes the result |

## Verification
Two things can land in the same cycle. First, the combinational decoder can take a new field on every cycle while the encoder search is running. The bench drives a full sweep of all 4096 fields at the same time as a list of encodes, and it compares both paths against its own models on every clock. Second, a new request can arrive in the very cycle that acknowledges a result. The bench holds `enc_valid_i` high with a different constant through the search, the done phase and the acknowledge cycle. The design passes only if that constant is never accepted, which shows up as a mismatch against the model in the following cycles.

// File: rtl/rotimm_pkg.sv
package rotimm_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BASE_W   = 8;
  localparam int unsigned ROT_W    = 4;
  localparam int unsigned ROT_STEP = 2;
  localparam int unsigned IMM_W    = BASE_W + ROT_W;
  localparam int unsigned ROT_N    = 1 << ROT_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IMM_W-1:0]  imm_t;
  typedef logic [ROT_W-1:0]  rot_t;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_SCAN = 2'd1,
    SC_DONE = 2'd2
  } scan_state_e;

  function automatic word_t rot_r(input word_t v, input int unsigned sh);
    int unsigned s;
    s = sh % DATA_W;
    if (s == 0) return v;
    return (v >> s) | (v << (DATA_W - s));
  endfunction

  function automatic word_t rot_l(input word_t v, input int unsigned sh);
    int unsigned s;
    s = sh % DATA_W;
    if (s == 0) return v;
    return (v << s) | (v >> (DATA_W - s));
  endfunction

  function automatic int unsigned rot_amount(input rot_t c);
    return ROT_STEP * 32'(c);
  endfunction

  function automatic word_t imm_expand(input imm_t f);
    return rot_r(word_t'(f[BASE_W-1:0]), rot_amount(f[IMM_W-1:BASE_W]));
  endfunction

  function automatic logic window_clear(input word_t v, input rot_t c);
    word_t p;
    p = rot_l(v, rot_amount(c));
    return (p[DATA_W-1:BASE_W] == '0);
  endfunction
endpackage

// File: rtl/rotimm_decode.sv
module rotimm_decode
  import rotimm_pkg::*;
(
  input  logic [IMM_W-1:0]  field_i,
  output logic [DATA_W-1:0] value_o
);
  always_comb value_o = imm_expand(field_i);
endmodule

// File: rtl/rotimm_search.sv
module rotimm_search
  import rotimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_value,
  output logic              out_done,
  output logic              out_unenc,
  output logic [IMM_W-1:0]  out_field,
  input  logic              out_ack,
  output logic              hit_o,
  output logic              exhaust_o
);
  scan_state_e       state_q;
  word_t             val_q;
  rot_t              cnt_q;
  imm_t              field_q;
  logic              unenc_q;
  word_t             probe;
  logic              in_scan;

  always_comb begin
    in_scan   = (state_q == SC_SCAN);
    probe     = rot_l(val_q, rot_amount(cnt_q));
    hit_o     = in_scan && window_clear(val_q, cnt_q);
    exhaust_o = in_scan && !hit_o && (cnt_q == rot_t'(ROT_N - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      val_q   <= '0;
      cnt_q   <= '0;
      field_q <= '0;
      unenc_q <= 1'b0;
    end else begin
      case (state_q)
        SC_IDLE: begin
          if (in_valid) begin
            val_q   <= in_value;
            cnt_q   <= '0;
            state_q <= SC_SCAN;
          end
        end
        SC_SCAN: begin
          if (hit_o) begin
            field_q <= {cnt_q, probe[BASE_W-1:0]};
            unenc_q <= 1'b0;
            state_q <= SC_DONE;
          end else if (exhaust_o) begin
            field_q <= '0;
            unenc_q <= 1'b1;
            state_q <= SC_DONE;
          end else begin
            cnt_q <= cnt_q + rot_t'(1);
          end
        end
        SC_DONE: begin
          if (out_ack) begin
            unenc_q <= 1'b0;
            state_q <= SC_IDLE;
          end
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == SC_IDLE);
  assign out_done  = (state_q == SC_DONE);
  assign out_unenc = out_done && unenc_q;
  assign out_field = field_q;
endmodule

// File: rtl/rotimm_codec.sv
module rotimm_codec
  import rotimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [IMM_W-1:0]  dec_field_i,
  output logic [DATA_W-1:0] dec_value_o,
  input  logic              enc_valid_i,
  output logic              enc_ready_o,
  input  logic [DATA_W-1:0] enc_value_i,
  output logic              enc_done_o,
  output logic              enc_unenc_o,
  output logic [IMM_W-1:0]  enc_field_o,
  input  logic              enc_ack_i
);
  logic scan_hit;
  logic scan_exhaust;

  rotimm_decode u_decode (
    .field_i (dec_field_i),
    .value_o (dec_value_o)
  );

  rotimm_search u_search (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (enc_valid_i),
    .in_ready  (enc_ready_o),
    .in_value  (enc_value_i),
    .out_done  (enc_done_o),
    .out_unenc (enc_unenc_o),
    .out_field (enc_field_o),
    .out_ack   (enc_ack_i),
    .hit_o     (scan_hit),
    .exhaust_o (scan_exhaust)
  );
endmodule

// File: rtl/rotimm_codec_chk.sv
module rotimm_codec_chk
  import rotimm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [IMM_W-1:0]  dec_field_i,
  input logic [DATA_W-1:0] dec_value_o,
  input logic              enc_valid_i,
  input logic              enc_ready_o,
  input logic [DATA_W-1:0] enc_value_i,
  input logic              enc_done_o,
  input logic              enc_unenc_o,
  input logic [IMM_W-1:0]  enc_field_o,
  input logic              enc_ack_i,
  input logic              scan_hit,
  input logic              scan_exhaust
);
  word_t taken_q;

  always_ff @(posedge clk) begin
    if (rst) taken_q <= '0;
    else if (enc_valid_i && enc_ready_o) taken_q <= enc_value_i;
  end

  p_plain_base_r1: assert property (@(posedge clk) disable iff (rst)
    (dec_field_i[IMM_W-1:BASE_W] == '0) |-> (dec_value_o == word_t'(dec_field_i[BASE_W-1:0])));

  p_ready_idle_r3: assert property (@(posedge clk) disable iff (rst)
    enc_ready_o |-> !enc_done_o);

  p_min_count_r4: assert property (@(posedge clk) disable iff (rst)
    (enc_done_o && !enc_unenc_o && enc_field_o[IMM_W-1:BASE_W] != '0)
      |-> (taken_q[DATA_W-1:BASE_W] != '0));

  p_hit_done_r5: assert property (@(posedge clk) disable iff (rst)
    scan_hit |=> (enc_done_o && !enc_unenc_o));

  p_exhaust_flag_r6: assert property (@(posedge clk) disable iff (rst)
    scan_exhaust |=> (enc_done_o && enc_unenc_o));

  p_unenc_zero_r6: assert property (@(posedge clk) disable iff (rst)
    enc_unenc_o |-> (enc_done_o && enc_field_o == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (enc_done_o && !enc_ack_i) |=>
      (enc_done_o && $stable(enc_field_o) && $stable(enc_unenc_o)));

  p_ack_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (enc_done_o && enc_ack_i) |=> enc_ready_o);

  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (enc_ready_o && !enc_done_o && !enc_unenc_o));

  p_round_trip_r9: assert property (@(posedge clk) disable iff (rst)
    (enc_done_o && !enc_unenc_o) |-> (imm_expand(enc_field_o) == taken_q));
endmodule

bind rotimm_codec rotimm_codec_chk u_chk (.*);

// File: tb/rotimm_codec_bench.sv
`timescale 1ns/100ps
module rotimm_codec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] dec_field = '0;
  logic [31:0] dec_value;
  logic        enc_valid = 1'b0;
  logic        enc_ready;
  logic [31:0] enc_value = '0;
  logic        enc_done;
  logic        enc_unenc;
  logic [11:0] enc_field;
  logic        enc_ack = 1'b0;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rotimm_codec u_rotimm_codec (
    .clk         (clk),
    .rst         (rst),
    .dec_field_i (dec_field),
    .dec_value_o (dec_value),
    .enc_valid_i (enc_valid),
    .enc_ready_o (enc_ready),
    .enc_value_i (enc_value),
    .enc_done_o  (enc_done),
    .enc_unenc_o (enc_unenc),
    .enc_field_o (enc_field),
    .enc_ack_i   (enc_ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference expansion: duplicate the zero-extended base and slide a window
  function automatic logic [31:0] ref_expand(input logic [11:0] f);
    logic [63:0] dbl;
    logic [31:0] w;
    w   = {24'd0, f[7:0]};
    dbl = {w, w} >> (2 * f[11:8]);
    return dbl[31:0];
  endfunction

  // Reference encoding: first count whose left rotation fits in 8 bits
  task automatic ref_encode(input logic [31:0] v, output logic [11:0] f,
                            output bit bad, output int cnt);
    bad = 1'b1; f = '0; cnt = 16;
    for (int c = 0; c < 16; c++) begin
      logic [31:0] r;
      int s;
      s = 2 * c;
      r = (s == 0) ? v : ((v << s) | (v >> (32 - s)));
      if (bad && r < 32'd256) begin
        bad = 1'b0; f = {c[3:0], r[7:0]}; cnt = c;
      end
    end
  endtask

  // Behavioural model: remaining-cycle countdown, not a state machine copy
  bit          m_busy = 0, m_done = 0, m_unenc = 0;
  logic [11:0] m_field = '0;
  int          m_left = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_unenc = 0; m_field = '0; m_left = 0;
    end else if (m_done) begin
      if (enc_ack) m_done = 0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin m_busy = 0; m_done = 1; end
    end else if (enc_valid) begin
      int c;
      bit b;
      ref_encode(enc_value, m_field, b, c);
      m_unenc = b;
      m_left  = b ? 16 : c + 1;
      m_busy  = 1;
    end
  end

  // Per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(enc_ready == (!m_busy && !m_done), "R3 ready", 32'(enc_ready), 32'(!m_busy && !m_done));
      check(enc_done == m_done, "R5 done timing", 32'(enc_done), 32'(m_done));
      if (m_done) begin
        check(enc_unenc == m_unenc, "R6 unencodable flag", 32'(enc_unenc), 32'(m_unenc));
        check(enc_field == m_field, "R4 field", 32'(enc_field), 32'(m_field));
      end
      check(dec_value == ref_expand(dec_field), "R1 decode", dec_value, ref_expand(dec_field));
    end
  end

  task automatic run_enc(input logic [31:0] v, input int hold, input bit poke, input bit trip);
    @(negedge clk); #1;
    enc_value = v; enc_valid = 1'b1;
    @(negedge clk); #1;
    if (poke) enc_value = ~v;
    else enc_valid = 1'b0;
    while (!enc_done) begin @(negedge clk); #1; end
    if (trip && !enc_unenc) begin
      dec_field = enc_field; #0.5;
      check(dec_value == v, "R9 round trip", dec_value, v);
    end
    repeat (hold) begin @(negedge clk); #1; end
    check(enc_done, "R7 held until ack", 32'(enc_done), 32'd1);
    enc_ack = 1'b1;
    @(negedge clk); #1;
    enc_ack = 1'b0; enc_valid = 1'b0;
    check(enc_ready, "R7 ready after ack", 32'(enc_ready), 32'd1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(enc_ready && !enc_done && !enc_unenc, "R8 reset state",
          {29'd0, enc_ready, enc_done, enc_unenc}, 32'h4);
    #1 rst = 1'b0;

    // R2 fixed decodes
    @(negedge clk); #1 dec_field = 12'hF41;
    #0.5 check(dec_value == 32'd260, "R2 decode F41", dec_value, 32'd260);
    dec_field = 12'h4FF;
    #0.5 check(dec_value == 32'hFF00_0000, "R2 decode 4FF", dec_value, 32'hFF00_0000);

    // Decoder sweep while the encoder runs a fixed list
    fork
      begin
        for (int f = 0; f < 4096; f++) begin
          @(negedge clk); #1 dec_field = f[11:0];
        end
      end
      begin
        run_enc(32'd1, 0, 0, 0);            // R4: 0x001
        run_enc(32'd260, 3, 1, 0);          // R4: 0xF41, R3 poke
        run_enc(32'd1020, 1, 0, 0);         // R4: 0xFFF
        run_enc(32'hF000_000F, 0, 1, 0);    // R4: 0x2FF
        run_enc(32'hFF00_0000, 2, 0, 0);    // R5: count 4
        run_enc(32'd0, 0, 0, 0);            // R5: count 0
        run_enc(32'h0000_0102, 2, 1, 0);    // R6: odd alignment
        run_enc(32'h1234_5678, 0, 0, 0);    // R6
        run_enc(32'h8000_0001, 1, 0, 0);    // R4: wraps, 0x106
      end
    join

    // R8: reset in mid search
    @(negedge clk); #1 enc_value = 32'h1234_5678; enc_valid = 1'b1;
    @(negedge clk); #1 enc_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    check(enc_ready && !enc_done && !enc_unenc, "R8 reset mid search",
          {29'd0, enc_ready, enc_done, enc_unenc}, 32'h4);
    #1 rst = 1'b0;

    // R9: random round trips
    for (int i = 0; i < 150; i++) begin
      logic [31:0] v;
      logic [11:0] rf;
      rf = 12'($urandom);
      v  = (i % 5 == 4) ? $urandom : ref_expand(rf);
      run_enc(v, i % 3, (i % 7) == 0, 1);
    end

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule